// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs single read and write cycles to external memory or I/O devices over a narrow bus. The low address byte and the data byte share one 8-bit port, and the high address byte has a port of its own. An internal requester starts a cycle by raising `req` with a 16-bit address, a direction flag, a data-memory select flag, a timing-mode flag and write data. The controller then sequences the bus strobes, and it answers with a one-cycle `ack`. Read data stays on `rdata` until a later read replaces it.

Every bus cycle has the same order. First the address strobe goes low with the low address on the shared port. Next the strobe goes high, which latches the address at the external device, and the port is released. For a write only, the write data is then set up for one clock. The data strobe then goes low for a counted number of clocks. Last comes a recovery phase with the data strobe high. The time of each phase is a parameter counted in clock periods. When the extended-timing flag is set on a request, that request's data strobe is two clocks longer. Read data is sampled at the clock edge where the data strobe rises.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `bus_as_n`, `bus_ds_n`, `bus_rw_n` and `bus_dm_n` are 1, `bus_ad_oe` and `ack` are 0, and `rdata` is 0. A reset in the middle of a cycle aborts that cycle at once.
- R2: After a request is accepted, `bus_as_n` is low for exactly AS_CYC clocks. During that time `bus_ad_oe` is 1 and `bus_ad_out` carries address bits 7:0. `bus_ah` carries address bits 15:8 for the whole bus cycle.
- R3: From the first address-strobe clock until the last recovery clock, `bus_rw_n` is 0 for a write (`wr`=1) and 1 for a read, and `bus_dm_n` is 0 when `dmem`=1 and 1 otherwise.
- R4: After `bus_as_n` rises, the port is released (`bus_ad_oe`=0) for exactly FLOAT_CYC clocks before anything else happens. `bus_ds_n` never goes low while `bus_as_n` is low or before the release ends. On reads the port is not driven while `bus_ds_n` is low.
- R5: `bus_ds_n` is low for DS_CYC clocks when `ext_timing` was 0 at acceptance, and for DS_CYC+EXT_CYC clocks when it was 1.
- R6: On a read, `rdata` takes the value that `bus_ad_in` had in the last clock with `bus_ds_n` low. After a write, `rdata` keeps its previous value.
- R7: On a write, `bus_ad_out` carries the write data with `bus_ad_oe`=1 in the clock before `bus_ds_n` falls, in every clock while it is low, and in the clock after it rises, with `bus_rw_n` still 0.
- R8: `ack` is high for exactly one clock. It is first sampled high AS_CYC+FLOAT_CYC+W+DS+REC_CYC+1 clocks after the accepting edge, where W is 1 for a write and 0 for a read, and DS is the strobe length from R5.
- R9: When `req` is held high across two requests, `bus_ds_n` is high for exactly REC_CYC+2 clocks between the data-strobe rise of the first cycle and the address-strobe fall of the next.
- R10: Address, data, direction, select and timing-mode inputs are latched when the request is accepted. Changing them during the cycle has no effect on the bus pins or on the strobe lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request; held until `ack` |
| addr | input | 16 | Cycle address |
| wr | input | 1 | 1 = write, 0 = read |
| dmem | input | 1 | Data-memory select for this cycle |
| ext_timing | input | 1 | Stretch the data strobe for this cycle |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last read data |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw_n | output | 1 | 1 = read, 0 = write |
| bus_dm_n | output | 1 | Data-memory select, active low |
| bus_ad_out | output | 8 | Shared address/data port, output side |
| bus_ad_oe | output | 1 | Output enable for the shared port |
| bus_ad_in | input | 8 | Shared address/data port, input side |
| bus_ah | output | 8 | High address byte |

## Verification
The bench builds the block with AS_CYC=2, FLOAT_CYC=2, DS_CYC=3, REC_CYC=2 and EXT_CYC=2. Because every phase is longer than one clock, a phase that is one clock long or one clock short shows up in the measured lengths and in the acknowledge latency. With these values the float phase and the write setup clock are also separate, observable stages. The extended mode gives a five-clock strobe, so it cannot be mistaken for the normal three-clock strobe, even when the mode input is toggled during a cycle.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_FLOAT  = 3'd2,
        PH_WSETUP = 3'd3,
        PH_STROBE = 3'd4,
        PH_RECOV  = 3'd5
    } bus_phase_e;

    typedef struct packed {
        logic wr;
        logic dmem;
        logic ext;
    } bus_flags_t;

endpackage

// File: rtl/mbc_phase_timer.sv
module mbc_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mbc_sequencer.sv
module mbc_sequencer
    import mbc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int AS_CYC    = 1,
    parameter int FLOAT_CYC = 1,
    parameter int DS_CYC    = 2,
    parameter int EXT_CYC   = 2,
    parameter int REC_CYC   = 1,
    parameter int CNT_W     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [2*DATA_W-1:0] addr,
    input  logic                wr,
    input  logic                dmem,
    input  logic                ext,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   ad_in,
    input  logic                tmr_done,
    output logic                tmr_load,
    output logic [CNT_W-1:0]    tmr_val,
    output bus_phase_e          phase,
    output logic                wr_q,
    output logic                dmem_q,
    output logic [2*DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0]   wdata_q,
    output logic [DATA_W-1:0]   rdata,
    output logic                ack
);

    localparam int AW = 2 * DATA_W;
    localparam logic [CNT_W-1:0] AS_LD  = CNT_W'(AS_CYC - 1);
    localparam logic [CNT_W-1:0] FL_LD  = CNT_W'(FLOAT_CYC - 1);
    localparam logic [CNT_W-1:0] DSN_LD = CNT_W'(DS_CYC - 1);
    localparam logic [CNT_W-1:0] DSX_LD = CNT_W'(DS_CYC + EXT_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    typedef struct packed {
        bus_phase_e        phase;
        bus_flags_t        flags;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic [CNT_W-1:0] ds_ld;

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ds_ld    = s_q.flags.ext ? DSX_LD : DSN_LD;
        case (s_q.phase)
            PH_IDLE: begin
                if (req && !s_q.ack) begin
                    s_d.addr       = addr;
                    s_d.wdata      = wdata;
                    s_d.flags.wr   = wr;
                    s_d.flags.dmem = dmem;
                    s_d.flags.ext  = ext;
                    s_d.phase      = PH_ADDR;
                    tmr_load       = 1'b1;
                    tmr_val        = AS_LD;
                end
            end
            PH_ADDR: begin
                if (tmr_done) begin
                    s_d.phase = PH_FLOAT;
                    tmr_load  = 1'b1;
                    tmr_val   = FL_LD;
                end
            end
            PH_FLOAT: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (s_q.flags.wr) begin
                        s_d.phase = PH_WSETUP;
                        tmr_val   = '0;
                    end else begin
                        s_d.phase = PH_STROBE;
                        tmr_val   = ds_ld;
                    end
                end
            end
            PH_WSETUP: begin
                if (tmr_done) begin
                    s_d.phase = PH_STROBE;
                    tmr_load  = 1'b1;
                    tmr_val   = ds_ld;
                end
            end
            PH_STROBE: begin
                if (tmr_done) begin
                    s_d.phase = PH_RECOV;
                    tmr_load  = 1'b1;
                    tmr_val   = REC_LD;
                    if (!s_q.flags.wr) begin
                        s_d.rdata = ad_in;
                    end
                end
            end
            PH_RECOV: begin
                if (tmr_done) begin
                    s_d.phase = PH_IDLE;
                    s_d.ack   = 1'b1;
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.flags <= '0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
            s_q.ack   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.phase;
    assign wr_q    = s_q.flags.wr;
    assign dmem_q  = s_q.flags.dmem;
    assign addr_q  = s_q.addr;
    assign wdata_q = s_q.wdata;
    assign rdata   = s_q.rdata;
    assign ack     = s_q.ack;

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ack |=> !s_q.ack);

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> ($stable(s_q.addr) && $stable(s_q.flags) && $stable(s_q.wdata)));

endmodule

// File: rtl/mbc_pin_drive.sv
module mbc_pin_drive
    import mbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bus_phase_e          phase,
    input  logic                wr_q,
    input  logic                dmem_q,
    input  logic [2*DATA_W-1:0] addr_q,
    input  logic [DATA_W-1:0]   wdata_q,
    output logic                as_n,
    output logic                ds_n,
    output logic                rw_n,
    output logic                dm_n,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [DATA_W-1:0]   ah
);

    logic busy;
    logic wr_drive;

    always_comb begin
        busy     = (phase != PH_IDLE);
        wr_drive = wr_q && ((phase == PH_WSETUP) || (phase == PH_STROBE) ||
                            (phase == PH_RECOV));
        as_n     = (phase != PH_ADDR);
        ds_n     = (phase != PH_STROBE);
        rw_n     = !(busy && wr_q);
        dm_n     = !(busy && dmem_q);
        ad_oe    = (phase == PH_ADDR) || wr_drive;
        ad_out   = (phase == PH_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
        ah       = addr_q[2*DATA_W-1:DATA_W];
    end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int AS_CYC    = 1,
    parameter int FLOAT_CYC = 1,
    parameter int DS_CYC    = 2,
    parameter int EXT_CYC   = 2,
    parameter int REC_CYC   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [2*DATA_W-1:0] addr,
    input  logic                wr,
    input  logic                dmem,
    input  logic                ext_timing,
    input  logic [DATA_W-1:0]   wdata,
    output logic                ack,
    output logic [DATA_W-1:0]   rdata,
    output logic                bus_as_n,
    output logic                bus_ds_n,
    output logic                bus_rw_n,
    output logic                bus_dm_n,
    output logic [DATA_W-1:0]   bus_ad_out,
    output logic                bus_ad_oe,
    input  logic [DATA_W-1:0]   bus_ad_in,
    output logic [DATA_W-1:0]   bus_ah
);

    localparam int MAX_A   = (AS_CYC > FLOAT_CYC) ? AS_CYC : FLOAT_CYC;
    localparam int MAX_B   = ((DS_CYC + EXT_CYC) > REC_CYC) ? (DS_CYC + EXT_CYC) : REC_CYC;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    bus_phase_e            phase;
    logic                  wr_q, dmem_q;
    logic [2*DATA_W-1:0]   addr_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  tmr_load, tmr_done;
    logic [CNT_W-1:0]      tmr_val;

    mbc_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    mbc_sequencer #(
        .DATA_W    (DATA_W),
        .AS_CYC    (AS_CYC),
        .FLOAT_CYC (FLOAT_CYC),
        .DS_CYC    (DS_CYC),
        .EXT_CYC   (EXT_CYC),
        .REC_CYC   (REC_CYC),
        .CNT_W     (CNT_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .addr     (addr),
        .wr       (wr),
        .dmem     (dmem),
        .ext      (ext_timing),
        .wdata    (wdata),
        .ad_in    (bus_ad_in),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .phase    (phase),
        .wr_q     (wr_q),
        .dmem_q   (dmem_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rdata    (rdata),
        .ack      (ack)
    );

    mbc_pin_drive #(.DATA_W(DATA_W)) i_pins (
        .phase   (phase),
        .wr_q    (wr_q),
        .dmem_q  (dmem_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .as_n    (bus_as_n),
        .ds_n    (bus_ds_n),
        .rw_n    (bus_rw_n),
        .dm_n    (bus_dm_n),
        .ad_out  (bus_ad_out),
        .ad_oe   (bus_ad_oe),
        .ah      (bus_ah)
    );

    // Strobe-length monitor for the R5 property.
    logic [CNT_W:0] ds_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_run_q <= '0;
        end else if (bus_ds_n) begin
            ds_run_q <= '0;
        end else begin
            ds_run_q <= ds_run_q + 1'b1;
        end
    end

    // R5
    ds_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ds_n) |-> ((int'(ds_run_q) == DS_CYC) || (int'(ds_run_q) == DS_CYC + EXT_CYC)));

    // R4
    float_after_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as_n) |-> !bus_ad_oe);

    // R4
    ds_after_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ds_n) |-> $past(bus_as_n));

    // R3
    ctl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_as_n) || $rose(bus_ds_n)) |-> ($stable(bus_rw_n) && $stable(bus_dm_n)));

    // R6
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ds_n) && bus_rw_n) |-> (rdata == $past(bus_ad_in)));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ds_n) && !bus_rw_n) |-> (bus_ad_oe && bus_ad_out == $past(bus_ad_out)));

    // R2
    ah_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ds_n |-> $stable(bus_ah));

endmodule

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/1ps
module test_mux_bus_ctrl;

    localparam int AS  = 2;
    localparam int FL  = 2;
    localparam int DS  = 3;
    localparam int EXT = 2;
    localparam int REC = 2;

    // {wr, dmem, ext, addr[15:0], wdata[7:0], read byte[7:0]}
    localparam logic [34:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 16'h12A5, 8'h00, 8'h3C},
        {1'b1, 1'b1, 1'b0, 16'hFF00, 8'h5A, 8'h00},
        {1'b0, 1'b1, 1'b1, 16'h00FF, 8'h00, 8'hC3},
        {1'b1, 1'b0, 1'b1, 16'h8001, 8'hA5, 8'h00},
        {1'b0, 1'b0, 1'b0, 16'h7E81, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 16'h0000, 8'hFF, 8'h00},
        {1'b0, 1'b1, 1'b1, 16'hFFFF, 8'h00, 8'hFF},
        {1'b1, 1'b1, 1'b1, 16'h4242, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0, dmem = 1'b0, ext_timing = 1'b0;
    logic [7:0]  wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic        bus_as_n, bus_ds_n, bus_rw_n, bus_dm_n, bus_ad_oe;
    logic [7:0]  bus_ad_out, bus_ad_in, bus_ah;
    logic [7:0]  mem_byte = '0;

    int tests = 0;
    int fails = 0;
    bit reported = 0;
    logic [7:0] last_rd = '0;

    int  since_ds = 0;
    bit  seen_ds = 0;
    logic prev_as = 1'b1;
    int  last_gap = -1;

    always #2.5 clk = ~clk;

    assign bus_ad_in = (!bus_ds_n && bus_rw_n) ? mem_byte : 8'hEE;

    mux_bus_ctrl #(
        .DATA_W(8), .AS_CYC(AS), .FLOAT_CYC(FL), .DS_CYC(DS),
        .EXT_CYC(EXT), .REC_CYC(REC)
    ) i_mux_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr),
        .dmem(dmem), .ext_timing(ext_timing), .wdata(wdata), .ack(ack),
        .rdata(rdata), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
        .bus_rw_n(bus_rw_n), .bus_dm_n(bus_dm_n), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ah(bus_ah)
    );

    // Gap monitor for R9: data-strobe-high clocks before the next address strobe.
    always @(negedge clk) begin
        if (!bus_ds_n) begin
            seen_ds  = 1;
            since_ds = 0;
        end else begin
            since_ds = since_ds + 1;
        end
        if (!bus_as_n && prev_as && seen_ds) last_gap = since_ds - 1;
        prev_as = bus_as_n;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic do_txn(input logic t_wr, input logic t_dm, input logic t_ext,
                          input logic [15:0] t_a, input logic [7:0] t_wd,
                          input logic [7:0] t_rb, input bit scramble, input bit keep);
        int n = 0, as_cnt = 0, ds_cnt = 0, fl_cnt = 0, exp_n;
        bit addr_bad = 0, ah_bad = 0, ctl_bad = 0, ord_bad = 0, wd_bad = 0, got_ack = 0;
        logic prev_ds = 1'b1, prev_oe = 1'b0;
        logic [7:0] prev_out = '0, exp_rd;
        @(negedge clk);
        req = 1'b1; addr = t_a; wr = t_wr; dmem = t_dm; ext_timing = t_ext;
        wdata = t_wd; mem_byte = t_rb;
        exp_n = AS + FL + (t_wr ? 1 : 0) + DS + (t_ext ? EXT : 0) + REC + 1;
        while (!got_ack && n < 400) begin
            @(negedge clk);
            n++;
            if (n == 1 && scramble) begin
                addr = ~t_a; wdata = ~t_wd; wr = ~t_wr; dmem = ~t_dm; ext_timing = ~t_ext;
            end
            if (ack) begin
                got_ack = 1;
            end else begin
                if (!bus_as_n) begin
                    as_cnt++;
                    if (!(bus_ad_oe && bus_ad_out == t_a[7:0])) addr_bad = 1;
                end
                if (bus_ah != t_a[15:8]) ah_bad = 1;
                if (bus_rw_n != !t_wr || bus_dm_n != !t_dm) ctl_bad = 1;
                if (bus_as_n && bus_ds_n && !bus_ad_oe && as_cnt > 0 && ds_cnt == 0) fl_cnt++;
                if (!bus_ds_n) begin
                    ds_cnt++;
                    if (!bus_as_n || fl_cnt < FL || (!t_wr && bus_ad_oe)) ord_bad = 1;
                    if (t_wr && !(bus_ad_oe && bus_ad_out == t_wd)) wd_bad = 1;
                    if (t_wr && prev_ds && !(prev_oe && prev_out == t_wd)) wd_bad = 1;
                end
                if (bus_ds_n && !prev_ds && t_wr &&
                    !(bus_ad_oe && bus_ad_out == t_wd && !bus_rw_n)) wd_bad = 1;
                prev_ds = bus_ds_n; prev_oe = bus_ad_oe; prev_out = bus_ad_out;
            end
        end
        if (n >= 400) chk(0, "watchdog transaction hang", n, exp_n);
        chk(got_ack && n == exp_n, "R8 ack latency", n, exp_n);
        chk(as_cnt == AS, "R2 address strobe length", as_cnt, AS);
        chk(!addr_bad && !ah_bad, "R2 address on port", {addr_bad, ah_bad}, 0);
        chk(!ctl_bad, "R3 direction and select", ctl_bad, 0);
        chk(fl_cnt == FL && !ord_bad, "R4 float and ordering", fl_cnt, FL);
        chk(ds_cnt == DS + (t_ext ? EXT : 0), "R5 data strobe length", ds_cnt,
            DS + (t_ext ? EXT : 0));
        if (t_wr) chk(!wd_bad, "R7 write data window", wd_bad, 0);
        exp_rd = t_wr ? last_rd : t_rb;
        chk(rdata == exp_rd, "R6 read data", rdata, exp_rd);
        last_rd = exp_rd;
        if (scramble) chk(!addr_bad && !ctl_bad && !wd_bad && as_cnt == AS,
                          "R10 fields latched", {addr_bad, ctl_bad, wd_bad}, 0);
        if (!keep) begin
            req = 1'b0; addr = '0; wdata = '0; wr = 1'b0; dmem = 1'b0; ext_timing = 1'b0;
            @(negedge clk);
            chk(!ack && bus_as_n && bus_ds_n, "R8 single ack pulse", ack, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while asserted
        chk(bus_as_n && bus_ds_n && bus_rw_n && bus_dm_n && !bus_ad_oe && !ack && rdata == 0,
            "R1 reset pins", {bus_as_n, bus_ds_n, bus_rw_n, bus_dm_n, bus_ad_oe, ack}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_as_n && bus_ds_n && !bus_ad_oe && !ack, "R1 idle after reset",
            {bus_as_n, bus_ds_n, bus_ad_oe, ack}, 4'b1100);

        for (int i = 0; i < 8; i++) begin
            do_txn(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:8],
                   VEC[i][7:0], (i % 3) == 1, 1'b0);
        end

        // R9 back-to-back with req held high
        do_txn(1'b0, 1'b0, 1'b0, 16'h3344, 8'h00, 8'h99, 1'b0, 1'b1);
        do_txn(1'b1, 1'b1, 1'b0, 16'h5566, 8'h77, 8'h00, 1'b0, 1'b0);
        chk(last_gap == REC + 2, "R9 strobe gap", last_gap, REC + 2);

        // R10 extended flag toggled mid-cycle on a read
        do_txn(1'b0, 1'b0, 1'b1, 16'hA0A0, 8'h00, 8'h6D, 1'b1, 1'b0);

        // R1 reset in the middle of a data strobe
        @(negedge clk);
        req = 1'b1; addr = 16'hBEEF; wr = 1'b0; dmem = 1'b1; ext_timing = 1'b1; mem_byte = 8'h11;
        for (int k = 0; k < 50 && bus_ds_n; k++) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(bus_as_n && bus_ds_n && bus_rw_n && bus_dm_n && !bus_ad_oe && !ack && rdata == 0,
            "R1 abort mid-cycle", {bus_ds_n, bus_dm_n, bus_ad_oe, rdata}, 11'h600);
        req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_as_n && bus_ds_n && !ack, "R1 stays idle after abort", {bus_as_n, bus_ds_n, ack}, 3'b110);
        last_rd = '0;
        do_txn(1'b0, 1'b0, 1'b0, 16'h0102, 8'h00, 8'h5E, 1'b0, 1'b0);

        report();
    end

endmodule